// File: doc/BRIEF.md
# Special CSR Access Unit

This block holds a small set of control and status registers next to a 32-bit core. It serves the two read-modify-write CSR operations of that core. An atomic swap returns the old register value and replaces it with the source operand. An atomic read-and-set returns the old value and ORs the source operand into the register as a bit mask. The registers are two flag groups, a combined view that reaches both groups through one index, and a window of modulus words. A wide datapath consumes the flags and the modulus. That datapath is outside this block.

Each access is a single-cycle request. The core presents the CSR index, the source value, the operation and whether the destination register is x0. In the same cycle the block returns the old value, an illegal-instruction flag and a write strobe. Register updates take effect at the next rising clock edge. An index that the block does not implement raises the illegal flag. Such an access has no other effect.

Top module: `spcsr_unit`

## Requirements
- R1: After reset every flag bit and every modulus word is zero.
- R2: A swap (`acc_set` = 0) returns the old value on `rd_data` and writes the source value, limited to the register's writable bits. The new value is visible from the next cycle.
- R3: A read-and-set (`acc_set` = 1) returns the old value and ORs the source into the writable bits. Bits that are already set stay set.
- R4: Index 0x7C0 holds flag group 0 and index 0x7C1 holds flag group 1. Each group holds FLAG_W (4) bits in bits [3:0]. Bits above the group read as zero and ignore writes.
- R5: Index 0x7C8 reads group 0 in bits [3:0] and group 1 in bits [7:4], and writes both groups at once. All higher bits read as zero.
- R6: Indices 0x7D0 through 0x7D8 are nine independent 32-bit modulus words. All 32 bits of each word are writable.
- R7: A swap with `dst_x0` = 1 does not read the register: `rd_data` is zero. The write still happens.
- R8: Any other index, such as 0xC00, 0x7C2 or 0x7D9, drives `acc_illegal` high in the same cycle. Such an access forces `rd_data` and `wr_fx` to zero and changes no register.
- R9: `wr_fx` is high for every legal swap. For a legal read-and-set it is high only when the source has a one in a writable bit.
- R10: While `acc_en` is low, all three outputs are zero and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Access request this cycle |
| acc_idx | input | 12 | CSR index |
| acc_src | input | XLEN | Source operand value or set mask |
| acc_set | input | 1 | 1 = read-and-set, 0 = swap |
| dst_x0 | input | 1 | Destination register is x0 |
| rd_data | output | XLEN | Old register value |
| acc_illegal | output | 1 | Index not implemented |
| wr_fx | output | 1 | Register written at the next edge |

## Verification
The bench writes ones into the bits above each flag group and checks that they read back as zero. A design that stored those bits would leak them into the flags or the combined view. It runs a read-and-set whose mask falls only on unwritable bits, and a read-and-set with a zero mask. A design that strobed `wr_fx` anyway would signal phantom side effects. It sends accesses to 0xC00, to the index just past the modulus window and to an unused flag index, then reads the neighbours back. A decoder that aliased or wrapped the index would corrupt a live register. It also swaps into x0 and drives traffic with `acc_en` low. A design that still read, or still wrote, would be caught by the returned data.

// File: rtl/spcsr_unit.sv
module spcsr_unit #(
  parameter int XLEN      = 32,
  parameter int FLAG_W    = 4,
  parameter int MOD_WORDS = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_en,
  input  logic [11:0]     acc_idx,
  input  logic [XLEN-1:0] acc_src,
  input  logic            acc_set,
  input  logic            dst_x0,
  output logic [XLEN-1:0] rd_data,
  output logic            acc_illegal,
  output logic            wr_fx
);
  localparam logic [11:0] IDX_F0  = 12'h7C0;
  localparam logic [11:0] IDX_F1  = 12'h7C1;
  localparam logic [11:0] IDX_FB  = 12'h7C8;
  localparam logic [11:0] IDX_MOD = 12'h7D0;
  localparam logic [11:0] IDX_END = IDX_MOD + 12'(MOD_WORDS);
  localparam logic [XLEN-1:0] FMASK = {{(XLEN-FLAG_W){1'b0}}, {FLAG_W{1'b1}}};
  localparam logic [XLEN-1:0] BMASK = {{(XLEN-2*FLAG_W){1'b0}}, {(2*FLAG_W){1'b1}}};

  logic [FLAG_W-1:0] flg0, flg1;
  logic [XLEN-1:0]   mod_q [MOD_WORDS];
  logic [XLEN-1:0]   old_v, wmask, new_v;
  logic [11:0]       mod_off;

  wire is_f0  = acc_idx == IDX_F0;
  wire is_f1  = acc_idx == IDX_F1;
  wire is_fb  = acc_idx == IDX_FB;
  wire is_mod = acc_idx >= IDX_MOD && acc_idx < IDX_END;
  wire legal  = is_f0 | is_f1 | is_fb | is_mod;
  wire live   = acc_en & legal;

  assign mod_off = acc_idx - IDX_MOD;

  always_comb begin
    old_v = '0;
    wmask = '0;
    if (is_f0) begin
      old_v = {{(XLEN-FLAG_W){1'b0}}, flg0};
      wmask = FMASK;
    end else if (is_f1) begin
      old_v = {{(XLEN-FLAG_W){1'b0}}, flg1};
      wmask = FMASK;
    end else if (is_fb) begin
      old_v = {{(XLEN-2*FLAG_W){1'b0}}, flg1, flg0};
      wmask = BMASK;
    end else if (is_mod) begin
      wmask = '1;
      for (int w = 0; w < MOD_WORDS; w++)
        if (mod_off == 12'(w)) old_v = mod_q[w];
    end
  end

  assign new_v       = acc_set ? (old_v | (acc_src & wmask)) : (acc_src & wmask);
  assign acc_illegal = acc_en & ~legal;
  assign wr_fx       = live & (~acc_set | (|(acc_src & wmask)));
  assign rd_data     = (live && !(!acc_set && dst_x0)) ? old_v : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg0 <= '0;
      flg1 <= '0;
      for (int w = 0; w < MOD_WORDS; w++) mod_q[w] <= '0;
    end else if (wr_fx) begin
      if (is_f0 || is_fb) flg0 <= new_v[FLAG_W-1:0];
      if (is_f1) flg1 <= new_v[FLAG_W-1:0];
      if (is_fb) flg1 <= new_v[2*FLAG_W-1:FLAG_W];
      for (int w = 0; w < MOD_WORDS; w++)
        if (is_mod && mod_off == 12'(w)) mod_q[w] <= new_v;
    end
  end
endmodule

// File: rtl/spcsr_unit_chk.sv
module spcsr_unit_chk #(
  parameter int XLEN   = 32,
  parameter int FLAG_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_en,
  input logic [11:0]     acc_idx,
  input logic [XLEN-1:0] acc_src,
  input logic            acc_set,
  input logic            dst_x0,
  input logic [XLEN-1:0] rd_data,
  input logic            acc_illegal,
  input logic            wr_fx
);
  wire in_mod = acc_idx >= 12'h7D0 && acc_idx <= 12'h7D8;

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_illegal |-> (!wr_fx && rd_data == '0));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> (!acc_illegal && !wr_fx && rd_data == '0));

  // R7
  swap_x0_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_set && dst_x0) |-> rd_data == '0);

  // R4
  flag_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && (acc_idx == 12'h7C0 || acc_idx == 12'h7C1)) |-> (rd_data >> FLAG_W) == '0);

  // R5
  both_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_idx == 12'h7C8) |-> (rd_data >> (2*FLAG_W)) == '0);

  // R2
  swap_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && acc_en && !acc_set && in_mod) && acc_en && in_mod &&
     acc_idx == $past(acc_idx) && !(!acc_set && dst_x0)) |-> rd_data == $past(acc_src));

  // R3
  set_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && acc_en && acc_set && in_mod) && acc_en && acc_set && in_mod &&
     acc_idx == $past(acc_idx)) |-> (rd_data & $past(acc_src)) == $past(acc_src));
endmodule

bind spcsr_unit spcsr_unit_chk #(.XLEN(XLEN), .FLAG_W(FLAG_W)) u_chk (.*);

// File: tb/spcsr_unit_test.sv
module spcsr_unit_test;
  localparam int CLK = 10;
  localparam int NV  = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0;
  logic [11:0] acc_idx = '0;
  logic [31:0] acc_src = '0;
  logic        acc_set = 1'b0;
  logic        dst_x0 = 1'b0;
  logic [31:0] rd_data;
  logic        acc_illegal, wr_fx;
  int          nchk = 0, nfail = 0;

  always #(CLK/2) clk = ~clk;

  spcsr_unit uut (.clk, .rst_n, .acc_en, .acc_idx, .acc_src, .acc_set, .dst_x0,
                  .rd_data, .acc_illegal, .wr_fx);

  // {req, en, idx, src, set, x0, exp_rd, exp_ill, exp_wr}
  localparam logic [84:0] VEC [NV] = '{
    {4'd4, 1'b1, 12'h7C0, 32'hFFFF_FFF5, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b1}, // R4 upper bits dropped
    {4'd3, 1'b1, 12'h7C0, 32'h0000_0002, 1'b1, 1'b0, 32'h0000_0005, 1'b0, 1'b1}, // R3
    {4'd9, 1'b1, 12'h7C0, 32'hFFFF_FFF0, 1'b1, 1'b0, 32'h0000_0007, 1'b0, 1'b0}, // R9 mask only unwritable
    {4'd7, 1'b1, 12'h7C1, 32'h0000_0009, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b1}, // R7
    {4'd5, 1'b1, 12'h7C8, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_0097, 1'b0, 1'b0}, // R5
    {4'd5, 1'b1, 12'h7C8, 32'h1234_56A3, 1'b0, 1'b0, 32'h0000_0097, 1'b0, 1'b1}, // R5 write both
    {4'd5, 1'b1, 12'h7C0, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0003, 1'b0, 1'b1}, // R5
    {4'd5, 1'b1, 12'h7C1, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_000A, 1'b0, 1'b1}, // R5
    {4'd6, 1'b1, 12'h7D0, 32'hDEAD_BEEF, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b1}, // R6
    {4'd6, 1'b1, 12'h7D8, 32'h1357_9BDF, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b1}, // R6
    {4'd3, 1'b1, 12'h7D0, 32'h0000_0010, 1'b1, 1'b0, 32'hDEAD_BEEF, 1'b0, 1'b1}, // R3
    {4'd7, 1'b1, 12'h7D8, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b1}, // R7 write still lands
    {4'd7, 1'b1, 12'h7D8, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R7
    {4'd8, 1'b1, 12'hC00, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0}, // R8
    {4'd8, 1'b1, 12'h7D9, 32'h0000_0005, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0}, // R8
    {4'd8, 1'b1, 12'h7C2, 32'h0000_000F, 1'b1, 1'b0, 32'h0000_0000, 1'b1, 1'b0}, // R8
    {4'd8, 1'b1, 12'h7C8, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R8 flags untouched
    {4'd8, 1'b1, 12'h7D0, 32'h0000_0000, 1'b1, 1'b0, 32'hDEAD_BEFF, 1'b0, 1'b0}, // R8
    {4'd10, 1'b0, 12'h7D0, 32'h0000_0001, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R10
    {4'd10, 1'b1, 12'h7D0, 32'h0000_0000, 1'b1, 1'b0, 32'hDEAD_BEFF, 1'b0, 1'b0}, // R10
    {4'd2, 1'b1, 12'h7D4, 32'hAAAA_5555, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b1}, // R2
    {4'd2, 1'b1, 12'h7D4, 32'h0000_0000, 1'b1, 1'b0, 32'hAAAA_5555, 1'b0, 1'b0}, // R2
    {4'd5, 1'b1, 12'h7C8, 32'h0000_00FF, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b1}, // R5
    {4'd5, 1'b1, 12'h7C8, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_00FF, 1'b0, 1'b0}  // R5
  };

  task automatic step(input logic en, input logic [11:0] idx, input logic [31:0] src,
                      input logic set, input logic x0, input logic [31:0] erd,
                      input logic eill, input logic ewr, input int req);
    @(negedge clk);
    acc_en = en; acc_idx = idx; acc_src = src; acc_set = set; dst_x0 = x0;
    #(CLK/4);
    nchk++;
    if (rd_data !== erd || acc_illegal !== eill || wr_fx !== ewr) begin
      nfail++;
      $display("FAIL R%0d idx=%h: rd=%h ill=%b wr=%b expected rd=%h ill=%b wr=%b",
               req, idx, rd_data, acc_illegal, wr_fx, erd, eill, ewr);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #(CLK * 100000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #(CLK * 3);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    step(1'b1, 12'h7C8, 32'h0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1);
    step(1'b1, 12'h7D3, 32'h0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1);
    for (int i = 0; i < NV; i++)
      step(VEC[i][80], VEC[i][79:68], VEC[i][67:36], VEC[i][35], VEC[i][34],
           VEC[i][33:2], VEC[i][1], VEC[i][0], int'(VEC[i][84:81]));
    // R1 reset again clears live state
    @(negedge clk) begin acc_en = 1'b0; rst_n = 1'b0; end
    @(negedge clk) rst_n = 1'b1;
    step(1'b1, 12'h7D0, 32'h0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1);
    step(1'b1, 12'h7C8, 32'h0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1);
    // R6 last word reachable, neighbour untouched
    step(1'b1, 12'h7D8, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 6);
    step(1'b1, 12'h7D7, 32'h0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 6);
    step(1'b1, 12'h7D8, 32'h0, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 6);
    @(negedge clk) acc_en = 1'b0;
    finish_run();
  end
endmodule